// File: doc/BRIEF.md
# Three-Axis Time-Division Excitation Sequencer

This block produces the select lines that drive external analog switches so that the three orthogonal coils of a transmit antenna are energised one after another. It runs from a fast reference clock. A prescaler turns that clock into a single-cycle tick every 2.5 ms. With the default 32 MHz clock and a divide ratio of 80000, the tick rate is 400 Hz. A two-bit phase counter advances on each tick. Its two bits are brought out as 200 Hz and 100 Hz square waves. A registered decoder turns the phase into three mutually exclusive axis selects.

The phase counter has four states. Each state lasts exactly one prescaler period. The first three states excite axis x, axis y and axis z, in that order. The fourth state is a quiet slot in which no axis is driven, so one full excitation cycle takes 10 ms. A one-cycle slot-start pulse marks the first cycle of every slot, so that receive-side acquisition can align to it. While the enable input is low, the prescaler and the phase counter both hold their values. The sequence therefore freezes and later resumes part-way through the slot it was in. Every output comes straight from a flip-flop, so the analog switches never see a combinational glitch.

Top module: `exc_sequencer`

## Requirements
- R1: While the synchronous active-high reset is sampled high, all three selects, the slot-start pulse and both square waves are 0. On the first clock edge after reset is released, the select for axis x goes high and slot_start pulses.
- R2: At most one bit of axis_sel is high in any cycle.
- R3: Phase 0 drives axis_sel = 3'b001 (axis x), phase 1 drives 3'b010 (axis y) and phase 2 drives 3'b100 (axis z), and the phases occur in that order.
- R4: Phase 3 is an idle slot with axis_sel = 3'b000. It is followed again by phase 0.
- R5: While enable stays high, every slot lasts exactly TICK_DIV clock cycles, so slot_start pulses are TICK_DIV cycles apart.
- R6: sq_fast equals bit 0 and sq_slow equals bit 1 of the phase. They change one clock cycle before axis_sel shows the new phase.
- R7: While en is low, the phase, the square waves and axis_sel hold their values. Counting resumes from the cycle count reached, so a slot totals TICK_DIV enabled cycles.
- R8: slot_start is high for exactly one cycle, in the first cycle of each new slot, aligned with the change of axis_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes the sequence |
| axis_sel | output | 3 | Registered one-hot axis select, bit 0 = x, bit 1 = y, bit 2 = z |
| sq_fast | output | 1 | Phase bit 0, a square wave at half the tick rate |
| sq_slow | output | 1 | Phase bit 1, a square wave at a quarter of the tick rate |
| slot_start | output | 1 | One-cycle pulse in the first cycle of each slot |

## Verification
The bench drops enable at random points, including the very cycle in which the prescaler reaches its terminal count. A design that lets the tick through while disabled, or that resets the prescaler during a pause, skips or stretches a slot. It measures the spacing between slot_start pulses, which exposes an off-by-one terminal count as slots one cycle too long or too short. It follows the sequence through the idle fourth slot and the wrap back to x, which catches a decoder that selects a fourth axis or skips the gap. It also applies reset in the middle of a run, which shows whether any select stays high after reset or whether the first slot after release lacks its start pulse.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int AXES = 3;

  typedef logic [1:0] phase_t;
  typedef logic [AXES-1:0] sel_t;

  // phase to one-hot axis select; phases at or above AXES are idle
  function automatic sel_t phase_to_sel(phase_t ph);
    sel_t s;
    s = '0;
    if (int'(ph) < AXES) s[ph] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/exc_prescale.sv
module exc_prescale #(
  parameter int DIV = 80000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign tick    = en && at_last;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/exc_phase_div.sv
module exc_phase_div
  import exc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/exc_slot_decode.sv
module exc_slot_decode
  import exc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  logic   adv,
  output sel_t   sel,
  output logic   start
);
  logic adv_d;
  logic first;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      start <= 1'b0;
      adv_d <= 1'b0;
      first <= 1'b1;
    end else begin
      sel   <= phase_to_sel(phase);
      adv_d <= adv;
      start <= adv_d | first;
      first <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int TICK_DIV = 80000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] axis_sel,
  output logic       sq_fast,
  output logic       sq_slow,
  output logic       slot_start
);
  logic   tick;
  phase_t phase;
  sel_t   sel;

  exc_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .en(en), .tick(tick)
  );

  exc_phase_div u_div (
    .clk(clk), .rst(rst), .adv(tick), .phase(phase)
  );

  exc_slot_decode u_dec (
    .clk(clk), .rst(rst), .phase(phase), .adv(tick),
    .sel(sel), .start(slot_start)
  );

  assign axis_sel = sel;
  assign sq_fast  = phase[0];
  assign sq_slow  = phase[1];
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk
  import exc_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] axis_sel,
  input logic       sq_fast,
  input logic       sq_slow,
  input logic       slot_start
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(axis_sel));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (axis_sel == 3'b000 && !slot_start && !sq_fast && !sq_slow));

  a_r7_freeze_sel: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##2 $stable(axis_sel));

  a_r7_freeze_phase: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({sq_slow, sq_fast}));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> !slot_start);

  a_r8_start_on_change: assert property (@(posedge clk) disable iff (rst)
    (axis_sel != $past(axis_sel)) |-> slot_start);

  a_r6_phase_leads: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (axis_sel == phase_to_sel($past({sq_slow, sq_fast}))));
endmodule

bind exc_sequencer exc_sequencer_chk i_chk (
  .clk(clk), .rst(rst), .en(en), .axis_sel(axis_sel),
  .sq_fast(sq_fast), .sq_slow(sq_slow), .slot_start(slot_start)
);

// File: tb/test_exc_sequencer.sv
module test_exc_sequencer;
  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] axis_sel;
  logic       sq_fast, sq_slow, slot_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_sequencer #(.TICK_DIV(DIV)) i_exc_sequencer (
    .clk(clk), .rst(rst), .en(en), .axis_sel(axis_sel),
    .sq_fast(sq_fast), .sq_slow(sq_slow), .slot_start(slot_start)
  );

  // reference: count enabled edges since reset
  int c = 0, p = 0, pp = 0, edges = 0;
  always @(posedge clk) begin
    if (rst) begin
      c <= 0; p <= 0; pp <= 0; edges <= 0;
    end else begin
      pp <= p; p <= c; c <= c + int'(en); edges <= edges + 1;
    end
  end

  function automatic logic [2:0] want_sel(int slot);
    case (slot % 4)
      0: return 3'b001;
      1: return 3'b010;
      2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  int last_start = -1;
  int cyc = 0;
  bit track_len = 0;

  task automatic step();
    @(negedge clk);
    cyc++;
    if (edges == 0) begin
      check("R1 sel in reset", int'(axis_sel), 0);
      check("R1 start in reset", int'(slot_start), 0);
      check("R1 square waves in reset", int'({sq_slow, sq_fast}), 0);
    end else begin
      check((p / DIV) % 4 == 3 ? "R4 idle slot" : "R3 axis order",
            int'(axis_sel), int'(want_sel(p / DIV)));
      check("R2 one-hot", int'($countones(axis_sel) <= 1), 1);
      check("R6 square waves", int'({sq_slow, sq_fast}), (c / DIV) % 4);
      check(edges == 1 ? "R1 first slot start" : "R8 slot start",
            int'(slot_start), int'(edges == 1 || (p / DIV) != (pp / DIV)));
      if (track_len && slot_start) begin
        if (last_start >= 0) check("R5 slot length", cyc - last_start, DIV);
        last_start = cyc;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    logic [1:0] held_ph;
    void'($urandom(32'd4242));
    repeat (3) step();
    rst = 1'b0;
    en  = 1'b1;
    // R5: free-running, several full cycles
    track_len = 1;
    repeat (DIV * 4 * 3) step();
    track_len = 0;
    // R7: pause mid-slot
    repeat (2) step();
    en = 1'b0;
    step(); step();
    held = axis_sel; held_ph = {sq_slow, sq_fast};
    repeat (DIV * 3) step();
    check("R7 frozen select", int'(axis_sel), int'(held));
    check("R7 frozen phase", int'({sq_slow, sq_fast}), int'(held_ph));
    en = 1'b1;
    repeat (DIV * 5) step();
    // random enable
    for (int i = 0; i < 1500; i++) begin
      en = ($urandom % 4) != 0;
      step();
    end
    // reset mid-run (R1)
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    en = 1'b1;
    repeat (DIV * 8) step();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule